// File: doc/BRIEF.md
# Trinary Pulse-Width Serial Encoder

This block turns nine three-state digits into a serial pulse-width stream on one output wire, for remote-control links. Each digit is low, high or open. It comes in already resolved, as a 2-bit code. A digit is sent as two pulses in a row, and each pulse is either short or long.

Pulling the active-low enable low starts a sequence. The sequence sends the same word twice, with a quiet gap between the two copies. While enable stays low, sequences follow one after another, with a further quiet gap between them. A single clock stands in for the oscillator. A `busy` output tells the system that a sequence is still being sent.

Top module: `trinary_pw_encoder`

## Requirements
- R1: While reset is asserted, and on leaving it, `ser_out` and `busy` are both 0.
- R2: While idle with `tx_en_n` high, `ser_out` and `busy` stay 0, whatever happens on `digits`.
- R3: A clock edge that finds the block idle and `tx_en_n` low starts a sequence. From the next cycle `busy` is 1 and `ser_out` is 1, which is the first clock of digit 1.
- R4: Each word sends digit 1 to digit 9 in order, 8 clocks per digit. Digit k is read from `digits[2k-1:2k-2]`. Each digit has two 4-clock pulse slots.
- R5: Code 2'b00 (low) is sent as two short pulses. A short pulse is 1 clock high, then 3 clocks low.
- R6: Code 2'b01 (high) is sent as two long pulses. A long pulse is 3 clocks high, then 1 clock low. The line is never high for more than 3 clocks in a row.
- R7: Code 2'b10 (open) is sent as a long pulse followed by a short pulse. Code 2'b11 is sent the same way.
- R8: Between the two words of a sequence, `ser_out` stays low for 24 clocks and `busy` stays 1.
- R9: `digits` is sampled on the edge that starts each word. Changes during a word do not affect that word.
- R10: If `tx_en_n` is high at the edge that ends the second word, both words have been sent in full and the block goes idle at once. `busy` only falls after an edge that saw `tx_en_n` high.
- R11: If `tx_en_n` is still low when the second word ends, 24 low clocks follow. If enable is still low at the end of that gap, a new sequence starts at once with freshly sampled digits. Otherwise the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n | input | 1 | Active-low transmit enable |
| digits | input | 18 | Nine 2-bit digit codes; digit 1 in bits [1:0] |
| ser_out | output | 1 | Serial pulse-width output |
| busy | output | 1 | High while a sequence is being sent |

## Verification
The hardest states to reach from the ports are the two edges where enable decides between going idle and carrying on:
- the edge that closes the second word;
- the edge that closes the trailing gap.

The stimulus releases enable at random points. Some points fall in the first word, some in the gap between words, some at the last clock of the second word and some inside the trailing gap. Other sequences chain with enable held low.

The digit inputs are also changed during each word and during the gaps. This shows that each word keeps the code sampled at its own start.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  typedef enum logic [1:0] {
    SYM_LOW      = 2'b00,
    SYM_HIGH     = 2'b01,
    SYM_OPEN     = 2'b10,
    SYM_OPEN_ALT = 2'b11
  } sym_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WORD_A,
    PH_GAP_A,
    PH_WORD_B,
    PH_GAP_B
  } phase_t;
endpackage

// File: rtl/tpe_period_timer.sv
module tpe_period_timer #(
  parameter int PERIOD_CLKS = 8,
  localparam int TW = $clog2(PERIOD_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [TW-1:0] tick,
  output logic          period_end
);
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CLKS - 1);

  logic [TW-1:0] tick_d;

  assign period_end = run && (tick == LAST);

  always_comb begin
    if (!run)            tick_d = '0;
    else if (period_end) tick_d = '0;
    else                 tick_d = tick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick_d;
  end
endmodule

// File: rtl/tpe_sequencer.sv
module tpe_sequencer
  import tpe_pkg::*;
#(
  parameter int DIGITS      = 9,
  parameter int GAP_PERIODS = 3,
  localparam int MAXC = (DIGITS > GAP_PERIODS) ? DIGITS : GAP_PERIODS,
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          period_end,
  output phase_t        phase,
  output logic [CW-1:0] idx,
  output logic          load
);
  localparam logic [CW-1:0] WORD_LAST = CW'(DIGITS - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_PERIODS - 1);

  phase_t        phase_d;
  logic [CW-1:0] idx_d;

  always_comb begin
    phase_d = phase;
    idx_d   = idx;
    load    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (!en_n) begin
          phase_d = PH_WORD_A;
          idx_d   = '0;
          load    = 1'b1;
        end
      end
      PH_WORD_A, PH_WORD_B: begin
        if (period_end) begin
          if (idx == WORD_LAST) begin
            idx_d = '0;
            if (phase == PH_WORD_A) phase_d = PH_GAP_A;
            else                    phase_d = en_n ? PH_IDLE : PH_GAP_B;
          end else begin
            idx_d = idx + 1'b1;
          end
        end
      end
      PH_GAP_A, PH_GAP_B: begin
        if (period_end) begin
          if (idx == GAP_LAST) begin
            idx_d = '0;
            if (phase == PH_GAP_A) begin
              phase_d = PH_WORD_B;
              load    = 1'b1;
            end else if (!en_n) begin
              phase_d = PH_WORD_A;
              load    = 1'b1;
            end else begin
              phase_d = PH_IDLE;
            end
          end else begin
            idx_d = idx + 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      phase <= phase_d;
      idx   <= idx_d;
    end
  end
endmodule

// File: rtl/tpe_pulse_gen.sv
module tpe_pulse_gen
  import tpe_pkg::*;
#(
  parameter int SLOT_CLKS = 4,
  parameter int SHORT_HI  = 1,
  parameter int LONG_HI   = 3,
  localparam int TW = $clog2(2 * SLOT_CLKS)
) (
  input  sym_t          sym,
  input  logic [TW-1:0] tick,
  input  logic          active,
  output logic          level
);
  localparam logic [TW-1:0] SLOT_T  = TW'(SLOT_CLKS);
  localparam logic [TW-1:0] SHORT_T = TW'(SHORT_HI);
  localparam logic [TW-1:0] LONG_T  = TW'(LONG_HI);

  logic          second;
  logic          is_long;
  logic [TW-1:0] pos;
  logic [TW-1:0] hi_len;

  always_comb begin
    second  = (tick >= SLOT_T);
    pos     = second ? (tick - SLOT_T) : tick;
    is_long = second ? (sym == SYM_HIGH) : (sym != SYM_LOW);
    hi_len  = is_long ? LONG_T : SHORT_T;
    level   = active && (pos < hi_len);
  end
endmodule

// File: rtl/trinary_pw_encoder.sv
module trinary_pw_encoder
  import tpe_pkg::*;
#(
  parameter int DIGITS      = 9,
  parameter int SLOT_CLKS   = 4,
  parameter int SHORT_HI    = 1,
  parameter int LONG_HI     = 3,
  parameter int GAP_PERIODS = 3,
  localparam int CODE_W = 2 * DIGITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_n,
  input  logic [CODE_W-1:0] digits,
  output logic              ser_out,
  output logic              busy
);
  localparam int PERIOD_CLKS = 2 * SLOT_CLKS;
  localparam int TW   = $clog2(PERIOD_CLKS);
  localparam int MAXC = (DIGITS > GAP_PERIODS) ? DIGITS : GAP_PERIODS;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic [TW-1:0]     tick;
  logic              period_end;
  phase_t            phase;
  logic [CW-1:0]     idx;
  logic              load;
  logic              in_word;
  logic [CODE_W-1:0] digits_q;
  sym_t              sym_arr [DIGITS];
  sym_t              sym_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign busy    = (phase != PH_IDLE);
  assign in_word = (phase == PH_WORD_A) || (phase == PH_WORD_B);

  tpe_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run        (busy),
    .tick       (tick),
    .period_end (period_end)
  );

  tpe_sequencer #(.DIGITS(DIGITS), .GAP_PERIODS(GAP_PERIODS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en_n       (tx_en_n),
    .period_end (period_end),
    .phase      (phase),
    .idx        (idx),
    .load       (load)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  digits_q <= '0;
    else if (load)    digits_q <= digits;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_unpack
    assign sym_arr[g] = sym_t'(digits_q[2*g +: 2]);
  end

  assign sym_cur = (32'(idx) < DIGITS) ? sym_arr[idx] : SYM_LOW;

  tpe_pulse_gen #(
    .SLOT_CLKS (SLOT_CLKS),
    .SHORT_HI  (SHORT_HI),
    .LONG_HI   (LONG_HI)
  ) u_pulse (
    .sym    (sym_cur),
    .tick   (tick),
    .active (in_word),
    .level  (ser_out)
  );
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en_n,
  input logic ser_out,
  input logic busy
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en_n) |=> (busy && ser_out));

  // R6
  max_high_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out && $past(ser_out) && $past(ser_out, 2)) |=> !ser_out);

  // R10
  stop_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_en_n));
endmodule

bind trinary_pw_encoder tpe_checker u_tpe_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_en_n (tx_en_n),
  .ser_out (ser_out),
  .busy    (busy)
);

// File: tb/test_trinary_pw_encoder.sv
module test_trinary_pw_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 9;
  localparam int SEQ_LEN = 192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en_n = 1'b1;
  logic [17:0] digits = '0;
  logic        ser_out;
  logic        busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trinary_pw_encoder i_trinary_pw_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en_n (tx_en_n),
    .digits  (digits),
    .ser_out (ser_out),
    .busy    (busy)
  );

  function automatic logic word_bit(input logic [17:0] d, input int u);
    int dig = u / 8;
    int tk  = u % 8;
    int pos = tk % 4;
    logic [1:0] c = d[2*dig +: 2];
    logic lng;
    if (tk < 4) lng = (c != 2'b00);
    else        lng = (c == 2'b01);
    return (pos == 0) || (lng && pos < 3);
  endfunction

  function automatic string code_tag(input logic [17:0] d, input int u);
    logic [1:0] c = d[2*(u/8) +: 2];
    if (c == 2'b00) return "R4/R9/R5";
    if (c == 2'b01) return "R4/R9/R6";
    return "R4/R9/R7";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2 ser_out", ser_out, 1'b0);
      check("R2 busy", busy, 1'b0);
      digits = 18'($urandom);
    end
  endtask

  // Called at a negedge; rel_t >= SEQ_LEN keeps enable low throughout.
  task automatic run_seq(input logic [17:0] da, input logic [17:0] db, input int rel_t);
    bit released = (rel_t <= 167);
    digits = da;
    tx_en_n = 1'b0;
    for (int t = 0; t < SEQ_LEN; t++) begin
      @(negedge clk);
      if (t < 72) begin
        check(code_tag(da, t), ser_out, word_bit(da, t));
        check("R3 busy", busy, 1'b1);
      end else if (t < 96) begin
        check("R8 gap ser_out", ser_out, 1'b0);
        check("R8 gap busy", busy, 1'b1);
      end else if (t < 168) begin
        check(code_tag(db, t - 96), ser_out, word_bit(db, t - 96));
        check("R10 busy word2", busy, 1'b1);
      end else if (released) begin
        check("R10 ser_out idle", ser_out, 1'b0);
        check("R10 busy idle", busy, 1'b0);
      end else begin
        check("R11 gap ser_out", ser_out, 1'b0);
        check("R11 gap busy", busy, 1'b1);
      end
      if (t == 30)  digits = 18'($urandom);
      if (t == 80)  digits = db;
      if (t == 120) digits = 18'($urandom);
      if (t == rel_t) tx_en_n = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    check("R1 ser_out in reset", ser_out, 1'b0);
    check("R1 busy in reset", busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ser_out after reset", ser_out, 1'b0);
    check("R1 busy after reset", busy, 1'b0);
    idle_cycles(6);

    // Directed codes: all low, all high, all open, alternate open code, mixed
    run_seq(18'h00000, 18'h15555, 10);
    idle_cycles(3);
    run_seq(18'h2AAAA, 18'h3FFFF, 0);
    idle_cycles(3);
    run_seq(18'h1B2C6, 18'h0E4D9, 167);   // release on last clock of word 2 (R10)
    idle_cycles(3);
    run_seq(18'h12345, 18'h2468A, 180);   // release inside trailing gap (R11)
    idle_cycles(4);

    // Continuous chain (R11), then release
    run_seq(18'h05A5A, 18'h0F0F0, 1000);
    run_seq(18'h3C3C3, 18'h11111, 1000);
    run_seq(18'h2D2D2, 18'h00FFF, 50);
    idle_cycles(5);

    // Random mix
    for (int n = 0; n < 14; n++) begin
      int r = $urandom_range(0, 3);
      int rel;
      case (r)
        0: rel = $urandom_range(0, 95);
        1: rel = $urandom_range(96, 167);
        2: rel = $urandom_range(168, 191);
        default: rel = 1000;
      endcase
      run_seq(18'($urandom), 18'($urandom), rel);
      if (rel != 1000) idle_cycles($urandom_range(1, 4));
    end
    tx_en_n = 1'b1;
    idle_cycles(SEQ_LEN + 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule